// File: doc/BRIEF.md
# Key-Protected Low-Speed Clock Selector

This block chooses which tick stream drives a chip's slow timekeeping domain. It picks either an internal RC oscillator, reduced by a fixed prescaler and then by a programmable divider, or an external 32 kHz crystal source. Both oscillators arrive as single-cycle enable pulses in one fabric clock domain. The chosen stream leaves as a clock-enable pulse. A second copy of it passes a software gate before it reaches an output pin.

Software drives the block through a small 32-bit register bus. The source-control register changes only when the upper half of the written word carries a fixed unlock key. This stops a stray store from moving the timekeeping domain onto another oscillator. When the external oscillator is reported as failing while it is selected, the block falls back to the internal path on its own. Software can disable that fallback with a bypass bit.

Top module: `lowspeed_clk_sel`

## Requirements
- R1: After reset, the source-control word (offset 0x00), the divider word (offset 0x08) and the gate word (offset 0x60) all read 0, and both tick outputs are low.
- R2: A write to offset 0x00 changes the control register only when write-data bits 31:16 equal 0x16AA. A write with any other key leaves the readback unchanged.
- R3: Offset 0x00 reads back the effective source in bit 0 (1 = external), the external-oscillator enable in bit 4 and the fallback bypass in bit 15. All other bits, the key field 31:16 included, read 0.
- R4: With the internal source in use, lsTick pulses once for every FIX_DIV*(P+1) intTick pulses. The pulse appears one cycle after the intTick that completes the count, and extTick has no effect.
- R5: The divider value P sits in bits 4:0 of offset 0x08. It is written without a key and reads back with all other bits 0.
- R6: With bit 0 and bit 4 both set, lsTick repeats every extTick one cycle later and ignores intTick. With bit 4 clear, the external path produces no ticks.
- R7: When bit 15 is clear and extFail is high in a cycle while the external source is in effect, the internal source takes over from the next cycle and bit 0 reads 0. This lasts until the next keyed control write.
- R8: With bit 15 set, extFail has no effect on the source in use.
- R9: Bit 0 of offset 0x08+0x58 (offset 0x60) enables outTick. When it is set, outTick equals lsTick. When it is clear, outTick stays low. The bit reads back at offset 0x60.
- R10: Reads of any other offset return 0, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| intTick | input | 1 | Internal RC oscillator enable pulse |
| extTick | input | 1 | External crystal enable pulse |
| extFail | input | 1 | External oscillator failure indication |
| lsTick | output | 1 | Selected low-speed clock enable |
| outTick | output | 1 | Gated copy of lsTick for the output pin |

## Verification
The bench builds the block with FIX_DIV set to 4 instead of the default 32. A whole internal period at P=2 then takes only twelve intTick pulses, so the bench can check the exact position of every divided pulse across two periods. The default ADDR_W is kept, which leaves unmapped offsets such as 0x04 and 0x0C available to probe. The generate branch for a fixed prescaler greater than one is the branch under test.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int DIV_W = 5;
  localparam logic [15:0] UNLOCK_KEY = 16'h16AA;
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_DIV  = 'h08;
  localparam int OFS_GATE = 'h60;
  localparam int BIT_SEL = 0;
  localparam int BIT_EXTEN = 4;
  localparam int BIT_BYPASS = 15;

  typedef struct packed {
    logic              useExt;
    logic              extEn;
    logic              gateOn;
    logic [DIV_W-1:0]  divSel;
  } lsc_strobe_t;
endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              extFail,
  output lsc_strobe_t       strb
);
  logic             selQ, extEnQ, bypassQ, fallenQ, gateQ;
  logic [DIV_W-1:0] divQ;
  logic             hitCtrl, hitDiv, hitGate, keyOk, effExt;

  assign hitCtrl = (busAddr == ADDR_W'(OFS_CTRL));
  assign hitDiv  = (busAddr == ADDR_W'(OFS_DIV));
  assign hitGate = (busAddr == ADDR_W'(OFS_GATE));
  assign keyOk   = (busWdata[31:16] == UNLOCK_KEY);
  assign effExt  = selQ & ~fallenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= 1'b0;
      extEnQ  <= 1'b0;
      bypassQ <= 1'b0;
      fallenQ <= 1'b0;
      gateQ   <= 1'b0;
      divQ    <= '0;
    end else begin
      if (busWe && hitCtrl && keyOk) begin
        selQ    <= busWdata[BIT_SEL];
        extEnQ  <= busWdata[BIT_EXTEN];
        bypassQ <= busWdata[BIT_BYPASS];
        fallenQ <= 1'b0;
      end else if (selQ && !bypassQ && extFail) begin
        fallenQ <= 1'b1;
      end
      if (busWe && hitDiv)  divQ  <= busWdata[DIV_W-1:0];
      if (busWe && hitGate) gateQ <= busWdata[0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (hitCtrl) begin
      busRdata[BIT_SEL]    = effExt;
      busRdata[BIT_EXTEN]  = extEnQ;
      busRdata[BIT_BYPASS] = bypassQ;
    end else if (hitDiv) begin
      busRdata[DIV_W-1:0] = divQ;
    end else if (hitGate) begin
      busRdata[0] = gateQ;
    end
  end

  assign strb.useExt = effExt;
  assign strb.extEn  = extEnQ;
  assign strb.gateOn = gateQ;
  assign strb.divSel = divQ;
endmodule

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int FIX_DIV = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        intTick,
  input  logic        extTick,
  input  lsc_strobe_t strb,
  output logic        lsTick,
  output logic        outTick
);
  logic             fixDone;
  logic [DIV_W-1:0] progCnt;
  logic             progHit, intDiv, srcTick;

  generate
    if (FIX_DIV > 1) begin : g_fixed
      localparam int FW = $clog2(FIX_DIV);
      localparam logic [FW-1:0] FIX_LAST = FW'(FIX_DIV - 1);
      logic [FW-1:0] fixCnt;
      always_ff @(posedge clk) begin
        if (!rstN) fixCnt <= '0;
        else if (intTick) fixCnt <= (fixCnt == FIX_LAST) ? '0 : fixCnt + 1'b1;
      end
      assign fixDone = intTick && (fixCnt == FIX_LAST);
    end else begin : g_direct
      assign fixDone = intTick;
    end
  endgenerate

  assign progHit = (progCnt >= strb.divSel);
  assign intDiv  = fixDone && progHit;

  always_ff @(posedge clk) begin
    if (!rstN) progCnt <= '0;
    else if (fixDone) progCnt <= progHit ? '0 : progCnt + 1'b1;
  end

  assign srcTick = strb.useExt ? (extTick && strb.extEn) : intDiv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsTick  <= 1'b0;
      outTick <= 1'b0;
    end else begin
      lsTick  <= srcTick;
      outTick <= srcTick && strb.gateOn;
    end
  end
endmodule

// File: rtl/lowspeed_clk_sel.sv
module lowspeed_clk_sel
  import lsc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int FIX_DIV = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              intTick,
  input  logic              extTick,
  input  logic              extFail,
  output logic              lsTick,
  output logic              outTick
);
  lsc_strobe_t strb;

  lsc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .extFail(extFail), .strb(strb)
  );

  lsc_datapath #(.FIX_DIV(FIX_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .intTick(intTick), .extTick(extTick),
    .strb(strb), .lsTick(lsTick), .outTick(outTick)
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              intTick,
  input logic              extTick,
  input logic              extFail,
  input logic              lsTick,
  input logic              outTick,
  input lsc_strobe_t       strb
);
  logic rdCtrl;
  assign rdCtrl = (busAddr == ADDR_W'(OFS_CTRL)) && !busWe;

  // R2: a write without the key keeps the stored enable
  a_r2_key_guard: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFS_CTRL) && busWdata[31:16] != UNLOCK_KEY)
      |=> $stable(strb.extEn));

  // R3: key field never reads back
  a_r3_key_hidden: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFS_CTRL)) |-> (busRdata[31:16] == 16'h0));

  // R4: internal source emits nothing without an intTick
  a_r4_int_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.useExt && !intTick) |=> !lsTick);

  // R5: divider field captures written bits
  a_r5_div_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFS_DIV)) |=> (strb.divSel == $past(busWdata[DIV_W-1:0])));

  // R6: enabled external path forwards its tick
  a_r6_ext_follow: assert property (@(posedge clk) disable iff (!rstN)
    (strb.useExt && strb.extEn && extTick) |=> lsTick);

  // R7: failure without bypass drops the external source
  a_r7_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (rdCtrl && busRdata[BIT_SEL] && !busRdata[BIT_BYPASS] && extFail) |=> !strb.useExt);

  // R8: bypass keeps the external source
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (rdCtrl && busRdata[BIT_SEL] && busRdata[BIT_BYPASS]) |=> strb.useExt);

  // R9: closed gate silences the pin output
  a_r9_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !strb.gateOn |=> !outTick);

  a_r9_gate_subset: assert property (@(posedge clk) disable iff (!rstN)
    outTick |-> lsTick);
endmodule

bind lowspeed_clk_sel lsc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .intTick(intTick),
  .extTick(extTick), .extFail(extFail), .lsTick(lsTick),
  .outTick(outTick), .strb(strb)
);

// File: tb/tb_lowspeed_clk_sel.sv
`timescale 1ns/1ps
module tb_lowspeed_clk_sel;
  localparam int AW = 8;
  localparam int FD = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          intTick = 1'b0, extTick = 1'b0, extFail = 1'b0;
  logic          lsTick, outTick;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lowspeed_clk_sel #(.ADDR_W(AW), .FIX_DIV(FD)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .intTick(intTick),
    .extTick(extTick), .extFail(extFail), .lsTick(lsTick), .outTick(outTick)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulse(input bit ext, output logic ls, output logic po);
    if (ext) extTick = 1'b1; else intTick = 1'b1;
    @(negedge clk);
    extTick = 1'b0; intTick = 1'b0;
    ls = lsTick; po = outTick;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h08, v); check("R1 div", v, 32'h0);
    rd(8'h60, v); check("R1 gate", v, 32'h0);
    check("R1 ticks", {30'h0, lsTick, outTick}, 32'h0);
  endtask

  task automatic t_internal();
    logic [31:0] v;
    logic ls, po;
    int bad = 0;
    wr(8'h08, 32'hFFFF_FFE2);
    rd(8'h08, v); check("R5 div readback", v, 32'h2);
    for (int k = 1; k <= 24; k++) begin
      pulse(1'b0, ls, po);
      check("R4 divided tick", {31'h0, ls}, {31'h0, (k % (FD * 3)) == 0});
    end
    pulse(1'b1, ls, po);
    check("R4 ext ignored", {31'h0, ls}, 32'h0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    wr(8'h00, 32'h0000_8011);
    rd(8'h00, v); check("R2 no key", v, 32'h0);
    wr(8'h00, 32'h16AB_0011);
    rd(8'h00, v); check("R2 wrong key", v, 32'h0);
    wr(8'h00, 32'h16AA_FFFF);
    rd(8'h00, v); check("R3 field mask", v, 32'h0000_8011);
    wr(8'h00, 32'h16AA_0011);
    rd(8'h00, v); check("R2 keyed write", v, 32'h0000_0011);
  endtask

  task automatic t_external();
    logic [31:0] v;
    logic ls, po;
    pulse(1'b1, ls, po); check("R6 ext tick", {31'h0, ls}, 32'h1);
    for (int k = 0; k < FD * 3; k++) begin
      pulse(1'b0, ls, po);
      check("R6 int ignored", {31'h0, ls}, 32'h0);
    end
    wr(8'h00, 32'h16AA_0001);
    pulse(1'b1, ls, po); check("R6 ext disabled", {31'h0, ls}, 32'h0);
    rd(8'h00, v); check("R3 sel only", v, 32'h1);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    logic ls, po;
    wr(8'h00, 32'h16AA_0011);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, v); check("R9 gate readback", v, 32'h1);
    pulse(1'b1, ls, po); check("R9 gate open", {30'h0, ls, po}, 32'h3);
    wr(8'h60, 32'h0);
    pulse(1'b1, ls, po); check("R9 gate closed", {30'h0, ls, po}, 32'h2);
  endtask

  task automatic t_fallback();
    logic [31:0] v;
    logic ls, po;
    wr(8'h00, 32'h16AA_0011);
    extFail = 1'b1; @(negedge clk); extFail = 1'b0;
    rd(8'h00, v); check("R7 fell back", v, 32'h10);
    pulse(1'b1, ls, po); check("R7 ext unused", {31'h0, ls}, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h00, v); check("R7 sticky", v, 32'h10);
    wr(8'h00, 32'h16AA_0011);
    rd(8'h00, v); check("R7 rearm", v, 32'h11);
  endtask

  task automatic t_bypass();
    logic [31:0] v;
    logic ls, po;
    wr(8'h00, 32'h16AA_8011);
    extFail = 1'b1; repeat (2) @(negedge clk); extFail = 1'b0;
    rd(8'h00, v); check("R8 bypass holds", v, 32'h8011);
    pulse(1'b1, ls, po); check("R8 ext active", {31'h0, ls}, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R10 read 0x04", v, 32'h0);
    rd(8'h0C, v); check("R10 read 0x0C", v, 32'h0);
    rd(8'h00, v); check("R10 ctrl untouched", v, 32'h8011);
    rd(8'h08, v); check("R10 div untouched", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal();
    t_key();
    t_external();
    t_gate();
    t_fallback();
    t_bypass();
    t_unmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule